// File: doc/BRIEF.md
# Wired Interrupt Source Bank

This block keeps the per-source state of a bank of wired interrupt inputs. Source numbers run from 1 to NSRC-1, and number 0 does not exist. For each source it holds a configuration word, a pending bit, an enable bit and the last sampled input level. A 3-bit trigger mode in the configuration decides how a line raises its pending bit: on a rising edge, on a falling edge, while high or while low. The mode also decides whether software may set or clear that bit. A source can instead be handed to a child domain. It is then frozen at not pending and not enabled.

Software talks to the bank through a command stream. Each command can write a configuration word, set or clear pending or enable for a source named by number, or set or clear them for the sources selected by a 32-bit bitmap word. The command port uses valid/ready. Ready rises on the first clock after reset and then stays high, so the bank never applies back-pressure. A command is accepted on every edge where valid and ready are both high. Reads are combinational: a selector picks one configuration word and one 32-bit word of each bitmap. A vector shows which sources are both enabled and pending, ready for a downstream arbiter.

Top module: `irq_src_bank`

## Requirements
- R1: A configuration write with bit 10 set and child_present high stores bit 10 and bits 9:0 (the child index). A write with bit 10 clear stores only bits 2:0 (the mode). A write with bit 10 set while child_present is low stores 0.
- R2: A configuration write that stores either zero or a value with bit 10 set clears the pending and enable bits of that source on the same edge.
- R3: Mode 4 (rising) sets pending when the synchronized input is 1 and the latched level is 0. Mode 5 (falling) sets pending when the synchronized input is 0 and the latched level is 1. A steady level never sets pending. Pending shows on the third clock edge after the input pin changes.
- R4: Mode 6 (high) sets pending whenever the synchronized input is 1, and mode 7 (low) whenever it is 0. When msi_mode is low, software cannot clear pending on a level source.
- R5: Software pending set and clear act on sources in modes 1 to 5. They have no effect on mode 0 or on delegated sources. On modes 6 and 7, a set works only when msi_mode is high and a clear never works.
- R6: Software enable set and clear act on any source whose mode is not 0 and which is not delegated. Otherwise they are ignored.
- R7: Source number 0 and numbers at or above NSRC are ignored by every command, and so are bitmap words beyond the last source.
- R8: In the bitmap views, bit i of word w is source 32*w+i. Bits for source 0 and for sources at or above NSRC read 0. The level view returns the latched input levels. A delegated source does not update its latched level.
- R9: act_vec bit s is high exactly when source s is both enabled and pending.
- R10: After reset, every configuration, pending, enable and level bit is 0.
- R11: cmd_ready is high from the first edge after reset. A command accepted on an edge is visible at the read ports after that edge. Operation codes: 0 writes a configuration; 1 sets pending by number; 2 clears pending by number; 3 sets enable by number; 4 clears enable by number; 5 to 8 do the same four actions by bitmap.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| msi_mode | input | 1 | Message delivery mode: lets software set pending on level sources |
| child_present | input | 1 | A child domain exists, so delegation may be stored |
| src_in | input | NSRC-1 | Wired interrupt lines, bit s is source s |
| cmd_valid | input | 1 | Command valid |
| cmd_ready | output | 1 | Command ready |
| cmd_op | input | 4 | Operation code (see R11) |
| cmd_sel | input | SEL_W | Source number for configuration writes, word number for bitmap commands |
| cmd_data | input | 32 | Configuration value, source number or bitmap |
| rd_sel | input | SEL_W | Read selector: source for rd_cfg, word for the bitmap words |
| rd_cfg | output | 11 | Stored configuration of source rd_sel |
| rd_pend_word | output | 32 | Pending bitmap word rd_sel |
| rd_level_word | output | 32 | Latched-level bitmap word rd_sel |
| rd_en_word | output | 32 | Enable bitmap word rd_sel |
| act_vec | output | NSRC-1 | Enabled-and-pending sources |

## Verification
A command accepted on an edge shows at the read ports right after that edge. The bench drives each command just after a falling edge and reads the result at the next falling edge. A change on an input pin passes two synchronizer flops and then the state register, so its effect on pending and on the level view appears on the third rising edge. The bench checks the cleared state after the second edge and the set state after the third. Level-low sources set pending again one edge after their configuration write, so the sweeps wait two edges before comparing.

// File: rtl/irq_src_pkg.sv
package irq_src_pkg;
  localparam int CFG_W   = 11;
  localparam int DLG_BIT = 10;
  localparam int CHILD_W = 10;
  localparam int MODE_W  = 3;

  localparam logic [MODE_W-1:0] MD_OFF  = 3'd0;
  localparam logic [MODE_W-1:0] MD_RISE = 3'd4;
  localparam logic [MODE_W-1:0] MD_FALL = 3'd5;
  localparam logic [MODE_W-1:0] MD_HIGH = 3'd6;
  localparam logic [MODE_W-1:0] MD_LOW  = 3'd7;

  typedef enum logic [3:0] {
    OP_CFG      = 4'd0,
    OP_SETP_NUM = 4'd1,
    OP_CLRP_NUM = 4'd2,
    OP_SETE_NUM = 4'd3,
    OP_CLRE_NUM = 4'd4,
    OP_SETP_MAP = 4'd5,
    OP_CLRP_MAP = 4'd6,
    OP_SETE_MAP = 4'd7,
    OP_CLRE_MAP = 4'd8
  } cmd_op_e;

  function automatic logic [CFG_W-1:0] cfg_mask(input logic [31:0] v, input logic child);
    if (v[DLG_BIT] && !child) return '0;
    if (v[DLG_BIT])           return {1'b1, v[CHILD_W-1:0]};
    return {{(CFG_W-MODE_W){1'b0}}, v[MODE_W-1:0]};
  endfunction
endpackage

// File: rtl/src_sync.sv
module src_sync #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] meta_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      meta_q <= '0;
      q      <= '0;
    end else begin
      meta_q <= d;
      q      <= meta_q;
    end
  end
endmodule

// File: rtl/src_slot.sv
module src_slot
  import irq_src_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             msi_mode,
  input  logic             lvl_in,
  input  logic             cfg_we,
  input  logic [CFG_W-1:0] cfg_wdata,
  input  logic             pend_set,
  input  logic             pend_clr,
  input  logic             en_set,
  input  logic             en_clr,
  output logic [CFG_W-1:0] cfg_q,
  output logic             pend_q,
  output logic             en_q,
  output logic             lvl_q
);
  logic              dlg, live, lvl_mode, hw_hit, set_ok, clr_ok, kill;
  logic [MODE_W-1:0] mode;

  assign dlg      = cfg_q[DLG_BIT];
  assign mode     = cfg_q[MODE_W-1:0];
  assign live     = !dlg && (mode != MD_OFF);
  assign lvl_mode = (mode == MD_HIGH) || (mode == MD_LOW);

  always_comb begin
    case (mode)
      MD_RISE: hw_hit = lvl_in && !lvl_q;
      MD_FALL: hw_hit = !lvl_in && lvl_q;
      MD_HIGH: hw_hit = lvl_in;
      MD_LOW:  hw_hit = !lvl_in;
      default: hw_hit = 1'b0;
    endcase
    if (dlg) hw_hit = 1'b0;
  end

  assign set_ok = pend_set && live && (!lvl_mode || msi_mode);
  assign clr_ok = pend_clr && live && !lvl_mode;
  assign kill   = cfg_we && (cfg_wdata[DLG_BIT] || (cfg_wdata == '0));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cfg_q  <= '0;
      pend_q <= 1'b0;
      en_q   <= 1'b0;
      lvl_q  <= 1'b0;
    end else begin
      if (cfg_we) cfg_q <= cfg_wdata;
      pend_q <= kill ? 1'b0 : ((pend_q && !clr_ok) || set_ok || hw_hit);
      en_q   <= kill ? 1'b0 : ((en_q && !(en_clr && live)) || (en_set && live));
      if (!dlg) lvl_q <= lvl_in;
    end
  end

  AST_KILL_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    kill |=> (!pend_q && !en_q)); // R2
  AST_DLG_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    (dlg && !pend_q && !en_q && !cfg_we) |=> (!pend_q && !en_q)); // R5
  AST_RISE_SETS: assert property (@(posedge clk) disable iff (!rst_n)
    (!dlg && mode == MD_RISE && !cfg_we && lvl_in && !lvl_q) |=> pend_q); // R3
  AST_LVL_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (!msi_mode && live && lvl_mode && pend_q && !cfg_we) |=> pend_q); // R4
  AST_OFF_NO_EN: assert property (@(posedge clk) disable iff (!rst_n)
    (!live && !en_q && !cfg_we) |=> !en_q); // R6
endmodule

// File: rtl/irq_src_bank.sv
module irq_src_bank
  import irq_src_pkg::*;
#(
  parameter int NSRC  = 40,
  parameter int SEL_W = 10
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             msi_mode,
  input  logic             child_present,
  input  logic [NSRC-1:1]  src_in,
  input  logic             cmd_valid,
  output logic             cmd_ready,
  input  logic [3:0]       cmd_op,
  input  logic [SEL_W-1:0] cmd_sel,
  input  logic [31:0]      cmd_data,
  input  logic [SEL_W-1:0] rd_sel,
  output logic [CFG_W-1:0] rd_cfg,
  output logic [31:0]      rd_pend_word,
  output logic [31:0]      rd_level_word,
  output logic [31:0]      rd_en_word,
  output logic [NSRC-1:1]  act_vec
);
  localparam int WORDS = (NSRC + 31) / 32;
  localparam int PAD_W = WORDS * 32;

  logic [NSRC-1:1]  lvl_sync;
  logic [NSRC-1:0]  pend_v, en_v, lvl_v;
  logic [CFG_W-1:0] cfg_arr [NSRC];
  logic [CFG_W-1:0] cfg_wval;
  logic [PAD_W-1:0] pend_pad, en_pad, lvl_pad;
  logic             rdy_q, fire;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rdy_q <= 1'b0;
    else        rdy_q <= 1'b1;
  end
  assign cmd_ready = rdy_q;
  assign fire      = cmd_valid && rdy_q;
  assign cfg_wval  = cfg_mask(cmd_data, child_present);

  src_sync #(.W(NSRC-1)) u_sync (
    .clk(clk), .rst_n(rst_n), .d(src_in), .q(lvl_sync)
  );

  assign pend_v[0]  = 1'b0;
  assign en_v[0]    = 1'b0;
  assign lvl_v[0]   = 1'b0;
  assign cfg_arr[0] = '0;

  for (genvar s = 1; s < NSRC; s++) begin : g_slot
    logic num_hit, map_hit;
    assign num_hit = (cmd_data == 32'(s));
    assign map_hit = (cmd_sel == SEL_W'(s / 32)) && cmd_data[s % 32];

    src_slot u_slot (
      .clk      (clk),
      .rst_n    (rst_n),
      .msi_mode (msi_mode),
      .lvl_in   (lvl_sync[s]),
      .cfg_we   (fire && cmd_op == OP_CFG && cmd_sel == SEL_W'(s)),
      .cfg_wdata(cfg_wval),
      .pend_set (fire && ((cmd_op == OP_SETP_NUM && num_hit) || (cmd_op == OP_SETP_MAP && map_hit))),
      .pend_clr (fire && ((cmd_op == OP_CLRP_NUM && num_hit) || (cmd_op == OP_CLRP_MAP && map_hit))),
      .en_set   (fire && ((cmd_op == OP_SETE_NUM && num_hit) || (cmd_op == OP_SETE_MAP && map_hit))),
      .en_clr   (fire && ((cmd_op == OP_CLRE_NUM && num_hit) || (cmd_op == OP_CLRE_MAP && map_hit))),
      .cfg_q    (cfg_arr[s]),
      .pend_q   (pend_v[s]),
      .en_q     (en_v[s]),
      .lvl_q    (lvl_v[s])
    );
  end

  assign pend_pad = PAD_W'(pend_v);
  assign en_pad   = PAD_W'(en_v);
  assign lvl_pad  = PAD_W'(lvl_v);

  always_comb begin
    rd_cfg        = '0;
    rd_pend_word  = '0;
    rd_level_word = '0;
    rd_en_word    = '0;
    for (int s = 1; s < NSRC; s++) begin
      if (rd_sel == SEL_W'(s)) rd_cfg = cfg_arr[s];
    end
    for (int w = 0; w < WORDS; w++) begin
      if (rd_sel == SEL_W'(w)) begin
        rd_pend_word  = pend_pad[w*32 +: 32];
        rd_level_word = lvl_pad[w*32 +: 32];
        rd_en_word    = en_pad[w*32 +: 32];
      end
    end
  end

  assign act_vec = pend_v[NSRC-1:1] & en_v[NSRC-1:1];

  AST_READY_STAYS: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_ready |=> cmd_ready); // R11
endmodule

// File: tb/irq_src_bank_bench.sv
module irq_src_bank_bench;
  import irq_src_pkg::*;
  localparam int NSRC = 40;
  localparam int SEL_W = 10;

  logic clk = 1'b0, rst_n = 1'b0, msi_mode = 1'b0, child_present = 1'b0;
  logic [NSRC-1:1] src_in = '0;
  logic cmd_valid = 1'b0, cmd_ready;
  logic [3:0] cmd_op = '0;
  logic [SEL_W-1:0] cmd_sel = '0, rd_sel = '0;
  logic [31:0] cmd_data = '0;
  logic [CFG_W-1:0] rd_cfg;
  logic [31:0] rd_pend_word, rd_level_word, rd_en_word;
  logic [NSRC-1:1] act_vec;
  int checks = 0, fails = 0;

  always #2.5 clk = ~clk;

  irq_src_bank #(.NSRC(NSRC), .SEL_W(SEL_W)) u_irq_src_bank (
    .clk(clk), .rst_n(rst_n), .msi_mode(msi_mode), .child_present(child_present),
    .src_in(src_in), .cmd_valid(cmd_valid), .cmd_ready(cmd_ready), .cmd_op(cmd_op),
    .cmd_sel(cmd_sel), .cmd_data(cmd_data), .rd_sel(rd_sel), .rd_cfg(rd_cfg),
    .rd_pend_word(rd_pend_word), .rd_level_word(rd_level_word), .rd_en_word(rd_en_word),
    .act_vec(act_vec)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  task automatic issue(input logic [3:0] op, input int sel, input logic [31:0] data);
    @(negedge clk);
    cmd_valid = 1'b1; cmd_op = op; cmd_sel = SEL_W'(sel); cmd_data = data;
    @(negedge clk);
    cmd_valid = 1'b0;
  endtask

  task automatic wait_cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  function automatic logic [31:0] fill(input int w, input logic b);
    logic [31:0] r;
    for (int i = 0; i < 32; i++) begin
      r[i] = (w*32 + i >= 1 && w*32 + i < NSRC) ? b : 1'b0;
    end
    return r;
  endfunction

  function automatic logic [31:0] bitof(input int s);
    return 32'(1) << (s % 32);
  endfunction

  task automatic rd(input int sel);
    rd_sel = SEL_W'(sel);
    #0.5;
  endtask

  task automatic chk_words(input string tag, input int kind, input logic b);
    for (int w = 0; w < 3; w++) begin
      rd(w);
      if (kind == 0)      chk(tag, rd_pend_word, fill(w, b));
      else if (kind == 1) chk(tag, rd_en_word, fill(w, b));
      else                chk(tag, rd_level_word, fill(w, b));
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL watchdog act=hung exp=done");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

  initial begin
    logic [47:0] av;
    logic setok, clrok, hw, pexp, eexp;
    wait_cyc(3);
    rst_n = 1'b1;
    wait_cyc(1);
    // R10 / R11 reset state
    chk("R11 ready", 32'(cmd_ready), 32'd1);
    chk_words("R10 pend", 0, 1'b0);
    chk_words("R10 en", 1, 1'b0);
    chk_words("R10 level", 2, 1'b0);
    rd(5); chk("R10 cfg", 32'(rd_cfg), 32'd0);
    chk("R10 act", 32'(act_vec[31:1]), 32'd0);

    // R5 R6 R9 sweep over delivery mode, trigger mode and every source
    for (int mm = 0; mm < 2; mm++) begin
      for (int m = 0; m < 8; m++) begin
        msi_mode = mm[0];
        for (int s = 1; s < NSRC; s++) begin
          issue(OP_CFG, s, 32'd0);
          issue(OP_CFG, s, 32'(m));
        end
        wait_cyc(2);
        hw    = (m == 7);
        setok = (m != 0) && (m < 6 || mm == 1);
        clrok = (m != 0) && (m < 6);
        chk_words("R4 level-low hw pend", 0, hw);
        for (int w = 0; w < 3; w++) issue(OP_SETP_MAP, w, 32'hFFFF_FFFF);
        pexp = hw | setok;
        chk_words("R5 map set pend", 0, pexp);
        for (int w = 0; w < 3; w++) issue(OP_CLRP_MAP, w, 32'hFFFF_FFFF);
        pexp = (pexp & !clrok) | hw;
        chk_words("R5 map clr pend", 0, pexp);
        for (int s = 1; s < NSRC; s++) issue(OP_SETP_NUM, 0, 32'(s));
        pexp = pexp | setok;
        chk_words("R5 num set pend", 0, pexp);
        for (int s = 1; s < NSRC; s++) issue(OP_SETE_NUM, 0, 32'(s));
        eexp = (m != 0);
        chk_words("R6 num set en", 1, eexp);
        av = 48'({act_vec, 1'b0});
        chk("R9 act w0", av[31:0], fill(0, pexp & eexp));
        chk("R9 act w1", 32'(av[47:32]), fill(1, pexp & eexp));
        for (int w = 0; w < 3; w++) issue(OP_CLRE_MAP, w, 32'hFFFF_FFFF);
        chk_words("R6 map clr en", 1, 1'b0);
        chk_words("R8 level idle", 2, 1'b0);
      end
    end

    // R7 out-of-range indices
    msi_mode = 1'b0;
    for (int s = 1; s < NSRC; s++) begin
      issue(OP_CFG, s, 32'd0);
      issue(OP_CFG, s, 32'd4);
    end
    issue(OP_SETP_NUM, 0, 32'd0);
    issue(OP_SETP_NUM, 0, 32'(NSRC));
    issue(OP_SETP_NUM, 0, 32'h8000_0001);
    issue(OP_SETP_MAP, 2, 32'hFFFF_FFFF);
    issue(OP_SETP_MAP, 0, 32'h0000_0001);
    issue(OP_SETE_NUM, 0, 32'(NSRC));
    issue(OP_SETE_NUM, 0, 32'd0);
    chk_words("R7 ignored pend", 0, 1'b0);
    chk_words("R7 ignored en", 1, 1'b0);
    issue(OP_SETP_NUM, 0, 32'(NSRC-1));
    rd(1); chk("R7 last source", rd_pend_word, bitof(NSRC-1));
    rd(0); chk("R7 word0 untouched", rd_pend_word, 32'd0);
    issue(OP_CLRP_NUM, 0, 32'(NSRC-1));

    // R3 rising edge on source 3 and its timing
    @(negedge clk); src_in[3] = 1'b1;
    @(negedge clk); @(negedge clk);
    rd(0); chk("R3 rise not yet", rd_pend_word, 32'd0);
    @(negedge clk);
    rd(0); chk("R3 rise pend", rd_pend_word, bitof(3));
    chk("R8 level latched", rd_level_word, bitof(3));
    issue(OP_CLRP_NUM, 0, 32'd3);
    wait_cyc(4);
    rd(0); chk("R3 steady high no pend", rd_pend_word, 32'd0);
    src_in[3] = 1'b0;
    wait_cyc(4);
    rd(0); chk("R3 fall ignored by rise", rd_pend_word, 32'd0);
    chk("R8 level dropped", rd_level_word, 32'd0);

    // R3 falling edge on source 5
    issue(OP_CFG, 5, 32'd5);
    src_in[5] = 1'b1;
    wait_cyc(4);
    rd(0); chk("R3 fall: rise ignored", rd_pend_word, 32'd0);
    src_in[5] = 1'b0;
    wait_cyc(3);
    rd(0); chk("R3 fall pend", rd_pend_word, bitof(5));
    issue(OP_CLRP_NUM, 0, 32'd5);

    // R4 level high on source 6, direct mode
    issue(OP_CFG, 6, 32'd6);
    src_in[6] = 1'b1;
    wait_cyc(4);
    rd(0); chk("R4 high pend", rd_pend_word, bitof(6));
    issue(OP_CLRP_NUM, 0, 32'd6);
    rd(0); chk("R4 clr ignored while high", rd_pend_word, bitof(6));
    src_in[6] = 1'b0;
    wait_cyc(4);
    issue(OP_CLRP_NUM, 0, 32'd6);
    rd(0); chk("R4 clr ignored after drop", rd_pend_word, bitof(6));
    issue(OP_CFG, 6, 32'd0);
    rd(0); chk("R2 zero cfg clears", rd_pend_word, 32'd0);

    // R2 R5 R6 R8 delegation on source 2
    child_present = 1'b1;
    issue(OP_SETP_NUM, 0, 32'd2);
    issue(OP_SETE_NUM, 0, 32'd2);
    rd(0); chk("R5 pend before dlg", rd_pend_word, bitof(2));
    chk("R6 en before dlg", rd_en_word, bitof(2));
    issue(OP_CFG, 2, 32'h0000_0405);
    rd(2); chk("R1 dlg stored", 32'(rd_cfg), 32'h405);
    rd(0); chk("R2 dlg clears pend", rd_pend_word, 32'd0);
    chk("R2 dlg clears en", rd_en_word, 32'd0);
    issue(OP_SETP_NUM, 0, 32'd2);
    issue(OP_SETE_NUM, 0, 32'd2);
    src_in[2] = 1'b1;
    wait_cyc(4);
    rd(0); chk("R5 dlg ignores set", rd_pend_word, 32'd0);
    chk("R6 dlg ignores en", rd_en_word, 32'd0);
    chk("R8 dlg level frozen", rd_level_word, 32'd0);
    src_in[2] = 1'b0;

    // R1 configuration masking
    issue(OP_CFG, 9, 32'hFFFF_FBFF);
    rd(9); chk("R1 mode only", 32'(rd_cfg), 32'h007);
    issue(OP_CFG, 33, 32'hFFFF_FFFF);
    rd(33); chk("R1 dlg with child", 32'(rd_cfg), 32'h7FF);
    child_present = 1'b0;
    issue(OP_CFG, 9, 32'h0000_0401);
    rd(9); chk("R1 dlg without child", 32'(rd_cfg), 32'h000);

    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end
endmodule